// File: doc/BRIEF.md
# Watchdog Timer with Keyed Refresh

This peripheral watches for a hung processor. A free-running divide-by-four prescaler paces a 24-bit down-counter. Software refreshes the counter by writing two key bytes in a row to a refresh register. If the counter reaches zero, or if software breaks the key sequence after the watchdog has started, a one-cycle reset request goes out to the system reset logic.

Software reaches the block through four 32-bit registers on a simple synchronous bus with separate write and read strobes. Read data is registered and valid in the cycle after the read strobe. Setting the enable bit does not start the watchdog on its own. The watchdog starts only after the first correct refresh. From then on, software can no longer disable it.

After a reset request the block freezes. It ignores refreshes until the system reset arrives.

Top module: `wdog_top`

## Requirements
- R1: Register offsets (decoded from bus_addr[3:2]) are: control 0x0, reload 0x4, refresh 0x8, live count 0xC. The control register holds enable in bit 0 and reset-enable in bit 1. Reads return the value in the cycle after bus_rd. Refresh reads as 0. After reset, control is 0 and both the reload and the counter are 0xFFFFFF.
- R2: A reload write keeps the low 24 bits of the data. A value below 0xFF is stored as 0xFF.
- R3: Until the watchdog has started, both control bits can be written freely, and the counter does not move.
- R4: A refresh is a write of 0xAA (data bits 7:0) to the refresh register, with the next bus access being a write of 0x55 to the same register. It loads the counter from the reload register. If enable is set, it starts the watchdog.
- R5: While started, the counter decrements once every 4 clocks, with the first decrement 4 clocks after the refresh. A reload of R therefore reaches zero exactly 4*R clocks after the refresh.
- R6: When the counter reaches zero while started with reset-enable set, wdt_reset_o is high for exactly one cycle. The counter then holds, and refreshes are ignored until system reset.
- R7: Once started, writes to control cannot clear either bit. Writing a 1 still sets a bit.
- R8: Started with reset-enable set: 0xAA followed by a refresh write of any other value raises wdt_reset_o in the cycle after that write.
- R9: Started with reset-enable set: 0xAA followed by any other bus access (a read, or a write to another register) raises wdt_reset_o in the cycle after that access.
- R10: A broken key sequence before start is discarded without a reset request. Started without reset-enable, neither expiry nor a broken sequence requests a reset, and the counter stops at 0.
- R11: A refresh before expiry reloads the counter and restarts the count, so no reset request occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_reset_o | output | 1 | One-cycle reset request |

## Verification
The bench measures the exact expiry latency from the second key write. A prescaler that is off by one, or that is not cleared on refresh, would shift the pulse by several clocks. It breaks the key sequence with a wrong second byte, an interposed read, and an interposed write, and expects an immediate pulse once the watchdog has started. A design that merely discarded these would miss the pulse. It repeats the broken sequences before start and with reset-enable clear, where a design that ignored those gates would reset the system spuriously. It also checks that control cannot be cleared after start, that the pulse lasts exactly one cycle, and that the counter stays frozen afterwards even when refreshed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_KICK   = 2'd2,
    SEL_COUNT  = 2'd3
  } reg_sel_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick_o = run_i && !clr_i && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i || !run_i) phase_q <= '0;
    else if (tick_o)            phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  // R5: ticks are never back to back
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       access_i,
  input  logic       kick_wr_i,
  input  logic [7:0] byte_i,
  output logic       good_o,
  output logic       broken_o
);
  logic armed_q;

  assign good_o   = armed_q && kick_wr_i && (byte_i == KEY_SECOND);
  assign broken_o = armed_q && access_i && !good_o;

  always_ff @(posedge clk) begin
    if (rst)           armed_q <= 1'b0;
    else if (armed_q)  armed_q <= armed_q && !access_i;
    else               armed_q <= kick_wr_i && (byte_i == KEY_FIRST);
  end

  // R9: a broken sequence always returns to the idle state
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
    broken_o |=> !armed_q);
  // R4: a completed sequence also returns to idle
  a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
    good_o |=> !armed_q);
endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
  parameter int               CNT_W   = 24,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o      = cnt_q;
  assign zero_hit_o = tick_i && !load_i && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)                             cnt_q <= RST_VAL;
    else if (load_i)                     cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  // R5: without a load or tick the count does not move
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int               DATA_W     = 32,
  parameter int               ADDR_W     = 4,
  parameter int               CNT_W      = 24,
  parameter int               DIV        = 4,
  parameter logic [CNT_W-1:0] RELOAD_MIN = CNT_W'(8'hFF),
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_reset_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  reg_sel_e         sel;
  logic             access, kick_wr;
  logic             en_q, rst_en_q, run_q, trip_q;
  logic [CNT_W-1:0] reload_q, cnt, wr_val;
  logic             good, broken, kick_ok, tick, zero_hit, fire;
  logic             unused_bits;

  assign sel         = reg_sel_e'(bus_addr[3:2]);
  assign access      = bus_wr || bus_rd;
  assign kick_wr     = bus_wr && (sel == SEL_KICK);
  assign wr_val      = bus_wdata[CNT_W-1:0];
  assign unused_bits = ^{bus_wdata[DATA_W-1:CNT_W], bus_addr[1:0]};

  wdog_key_seq u_key (
    .clk       (clk),
    .rst       (rst),
    .access_i  (access),
    .kick_wr_i (kick_wr),
    .byte_i    (bus_wdata[7:0]),
    .good_o    (good),
    .broken_o  (broken)
  );

  assign kick_ok = good && !trip_q;

  wdog_prescaler #(.DIV(DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (kick_ok),
    .run_i  (run_q && !trip_q),
    .tick_o (tick)
  );

  wdog_downcount #(.CNT_W(CNT_W), .RST_VAL(RELOAD_RST)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (kick_ok),
    .load_val_i (reload_q),
    .tick_i     (tick),
    .cnt_o      (cnt),
    .zero_hit_o (zero_hit)
  );

  assign fire = !trip_q && run_q && rst_en_q && (zero_hit || broken);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= 1'b0;
      rst_en_q    <= 1'b0;
      run_q       <= 1'b0;
      trip_q      <= 1'b0;
      reload_q    <= RELOAD_RST;
      wdt_reset_o <= 1'b0;
    end else begin
      if (bus_wr && sel == SEL_CTRL) begin
        en_q     <= bus_wdata[0] || (run_q && en_q);
        rst_en_q <= bus_wdata[1] || (run_q && rst_en_q);
      end
      if (bus_wr && sel == SEL_RELOAD)
        reload_q <= (wr_val < RELOAD_MIN) ? RELOAD_MIN : wr_val;
      if (kick_ok && en_q) run_q <= 1'b1;
      if (fire)            trip_q <= 1'b1;
      wdt_reset_o <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (sel)
        SEL_CTRL:   bus_rdata <= DATA_W'({rst_en_q, en_q});
        SEL_RELOAD: bus_rdata <= {{PAD_W{1'b0}}, reload_q};
        SEL_COUNT:  bus_rdata <= {{PAD_W{1'b0}}, cnt};
        default:    bus_rdata <= '0;
      endcase
    end
  end

  // R6: request lasts a single cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_o |=> !wdt_reset_o);
  // R6: counter frozen after a request
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    trip_q |=> $stable(cnt));
  // R7: control bits cannot be cleared once started
  a_r7_en_lock: assert property (@(posedge clk) disable iff (rst)
    (run_q && en_q) |=> en_q);
  a_r7_rsten_lock: assert property (@(posedge clk) disable iff (rst)
    (run_q && rst_en_q) |=> rst_en_q);
  // R2: stored reload never under the floor
  a_r2_floor: assert property (@(posedge clk) disable iff (rst)
    reload_q >= RELOAD_MIN);
  // R10: no request unless started with reset-enable
  a_r10_gated: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_o |-> (run_q && rst_en_q));
endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_reset_o;

  int vectors = 0;
  int miss = 0;
  int pulses = 0;
  bit finished = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_RELOAD = 4'h4, A_KICK = 4'h8, A_COUNT = 4'hC;

  always #5 clk = ~clk;

  wdog_top u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_reset_o(wdt_reset_o)
  );

  always @(negedge clk) if (wdt_reset_o === 1'b1) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic kick();
    wr(A_KICK, 32'hAA);
    wr(A_KICK, 32'h55);
  endtask

  task automatic t_reset_values();
    logic [31:0] d;
    do_reset();
    chk("R1 reset output", {31'b0, wdt_reset_o}, 32'h0);
    rd(A_CTRL, d);   chk("R1 control reset", d, 32'h0);
    rd(A_RELOAD, d); chk("R1 reload reset", d, 32'h00FF_FFFF);
    rd(A_COUNT, d);  chk("R1 count reset", d, 32'h00FF_FFFF);
    rd(A_KICK, d);   chk("R1 refresh reads zero", d, 32'h0);
  endtask

  task automatic t_reload_clamp();
    logic [31:0] d;
    do_reset();
    wr(A_RELOAD, 32'h10);        rd(A_RELOAD, d); chk("R2 clamp low", d, 32'hFF);
    wr(A_RELOAD, 32'h1234);      rd(A_RELOAD, d); chk("R2 normal", d, 32'h1234);
    wr(A_RELOAD, 32'hFF12_3456); rd(A_RELOAD, d); chk("R2 upper byte dropped", d, 32'h12_3456);
  endtask

  task automatic t_prestart();
    logic [31:0] d;
    int p0;
    do_reset();
    wr(A_CTRL, 32'h3); rd(A_CTRL, d); chk("R3 set bits", d, 32'h3);
    wr(A_CTRL, 32'h0); rd(A_CTRL, d); chk("R3 clear before start", d, 32'h0);
    wr(A_CTRL, 32'h3);
    p0 = pulses;
    wr(A_KICK, 32'hAA); wr(A_KICK, 32'h12);
    wr(A_KICK, 32'hAA); rd(A_CTRL, d);
    repeat (20) @(posedge clk);
    chk("R10 no request before start", pulses - p0, 0);
    rd(A_COUNT, d); chk("R3 count idle", d, 32'h00FF_FFFF);
  endtask

  task automatic t_count();
    logic [31:0] d;
    do_reset();
    wr(A_RELOAD, 32'h100);
    wr(A_CTRL, 32'h3);
    kick();
    rd(A_COUNT, d); chk("R4 loaded", d, 32'h100);
    repeat (8) @(posedge clk);
    rd(A_COUNT, d); chk("R5 two decrements", d, 32'hFE);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d); chk("R7 cannot clear", d, 32'h3);
  endtask

  task automatic t_expiry();
    logic [31:0] d;
    int n, p0;
    do_reset();
    wr(A_RELOAD, 32'h0);
    wr(A_CTRL, 32'h3);
    p0 = pulses;
    kick();
    n = 0;
    while (wdt_reset_o !== 1'b1 && n < 5000) begin
      @(posedge clk); #1; n++;
    end
    chk("R5 expiry latency", n, 1020);
    @(posedge clk); #1;
    chk("R6 one cycle", {31'b0, wdt_reset_o}, 32'h0);
    kick();
    rd(A_COUNT, d); chk("R6 frozen at zero", d, 32'h0);
    repeat (50) @(posedge clk);
    chk("R6 single request", pulses - p0, 1);
  endtask

  task automatic t_bad_byte();
    do_reset();
    wr(A_RELOAD, 32'h200);
    wr(A_CTRL, 32'h3);
    kick();
    repeat (5) @(posedge clk);
    wr(A_KICK, 32'hAA);
    wr(A_KICK, 32'h56);
    chk("R8 immediate request", {31'b0, wdt_reset_o}, 32'h1);
    @(posedge clk); #1;
    chk("R8 request drops", {31'b0, wdt_reset_o}, 32'h0);
  endtask

  task automatic t_interleave();
    logic [31:0] d;
    do_reset();
    wr(A_RELOAD, 32'h200);
    wr(A_CTRL, 32'h3);
    kick();
    wr(A_KICK, 32'hAA);
    rd(A_RELOAD, d);
    chk("R9 read interposed", {31'b0, wdt_reset_o}, 32'h1);
    do_reset();
    wr(A_CTRL, 32'h3);
    kick();
    wr(A_KICK, 32'hAA);
    wr(A_RELOAD, 32'h300);
    chk("R9 write interposed", {31'b0, wdt_reset_o}, 32'h1);
  endtask

  task automatic t_no_rsten();
    logic [31:0] d;
    int p0;
    do_reset();
    wr(A_RELOAD, 32'hFF);
    wr(A_CTRL, 32'h1);
    p0 = pulses;
    kick();
    wr(A_KICK, 32'hAA); wr(A_KICK, 32'h00);
    repeat (1100) @(posedge clk);
    chk("R10 no request without reset-enable", pulses - p0, 0);
    rd(A_COUNT, d); chk("R10 count stops at zero", d, 32'h0);
    wr(A_CTRL, 32'h2); rd(A_CTRL, d); chk("R7 bit can still be set", d, 32'h3);
    wr(A_CTRL, 32'h0); rd(A_CTRL, d); chk("R7 still locked", d, 32'h3);
  endtask

  task automatic t_refresh();
    logic [31:0] d;
    int p0;
    do_reset();
    wr(A_RELOAD, 32'hFF);
    wr(A_CTRL, 32'h3);
    p0 = pulses;
    kick();
    repeat (600) @(posedge clk);
    kick();
    repeat (600) @(posedge clk);
    rd(A_COUNT, d); chk("R11 restarted count", d, 32'd105);
    chk("R11 no request", pulses - p0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  initial begin
    t_reset_values();
    t_reload_clamp();
    t_prestart();
    t_count();
    t_expiry();
    t_bad_byte();
    t_interleave();
    t_no_rsten();
    t_refresh();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule